// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Receiver

This block watches a demodulated infrared line and turns it into a stream of symbols. Each symbol has two widths: the mark, which is the time the line spends in its active level, and the space that follows it. Both widths are counted in fixed time units. One unit lasts `(prescaler + 1) * UNIT_TICKS` clock cycles, so a prescaler programmed as the clock rate in MHz minus one, with `UNIT_TICKS = 10`, gives a 10 µs unit. Each finished symbol is packed into one 32-bit word and written into a receive FIFO.

Software reaches the block through a simple word-addressed register port and reads symbols out of the FIFO. Three sticky status bits tell it what has happened: the FIFO has reached its threshold, the line has stayed idle for the programmed limit, or a symbol was lost because the FIFO was full. Each status bit can be masked, and one interrupt line is raised while any unmasked bit is set.

Register word addresses:

| Address | Register | Contents |
|---|---|---|
| 0 | control | enable in bit 0 |
| 1 | configuration | fields listed in R2 to R7 |
| 2 | busy | busy flag |
| 3 | level | number of entries in the FIFO |
| 4 | data | oldest FIFO entry |
| 5 | mask | mask bits 10:8 |
| 6 | status | status and masked status |
| 7 | clear | clear bits 18:16 |
| 8 | go | any write starts capture |

Top module: `irrx_capture`

## Requirements
- R1: After reset, busy, irq and the level register all read 0. Writing 1 to bit 0 of the control register makes busy read 1 for BUSY_CYCLES (default 4) cycles, after which it reads 0 again.
- R2: Symbols are captured only when all of the following hold: the block is enabled, a write of any value has been made to the go register, and configuration bit 7 (raw capture) is 1. Edges on the line at any other time leave the FIFO empty. Writing 0 to the control register stops capture.
- R3: The prescaler is configuration bits 6:0; one unit lasts (prescaler+1)*10 cycles. Each entry holds the mark width in bits 15:0 and the space width in bits 31:16, both in units.
- R4: With format 0 (configuration bits 15:14 = 0), a high line is a mark. A symbol opens on a low-to-high transition and closes at the next low-to-high transition.
- R5: With format 1 (configuration bits 15:14 = 1), the polarity is inverted: a low line is a mark.
- R6: A symbol also closes when mark plus space reaches the maximum width held in configuration bits 31:16. In that case the entry is pushed with that space value, status bit 9 (timeout) is set, and the receiver waits for the next mark.
- R7: The level register returns the number of entries in the FIFO. Each read of the data register returns the oldest entry and removes it, so entries come out in arrival order. A read of the data register while the FIFO is empty returns 0.
- R8: Status bit 8 (receive) is set in every cycle in which the level is at least the value of configuration bits 13:8 plus 1.
- R9: When a symbol closes while all FIFO_DEPTH (default 64) entries are in use, the new symbol is dropped, status bit 10 (overflow) is set, and the stored entries are kept unchanged.
- R10: Writing 1 to clear bit 16, 17 or 18 clears status bit 8, 9 or 10 respectively. A 0 in a clear bit leaves the matching status bit as it is.
- R11: A 1 in mask bit 8, 9 or 10 disables the matching status bit; the mask resets to all 1s. Status bits 26:24 read as the status bits ANDed with the inverted mask, and irq is the OR of those three masked bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of the data register pops one entry |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| rx_in | input | 1 | Demodulated infrared line, asynchronous to clk |
| irq | output | 1 | OR of the unmasked status bits |

## Verification
The assertions check properties that hold on every cycle:
- busy rises only because of an enabling write;
- no symbol is pushed while capture is off;
- a timeout or a drop is always followed by its status bit;
- the FIFO level never goes above the depth;
- the receive bit follows the level threshold.

Width values, quantization at each prescaler setting, polarity under both formats, the order in which entries come out, and the behaviour of clear and mask are shown only by the bench's scenarios. Those scenarios compare the popped words against symbol lengths chosen at random, and cover filling the FIFO past its depth.

// File: rtl/irrx_pkg.sv
package irrx_pkg;

    localparam int WIDTH_W = 16;

    typedef enum logic [3:0] {
        RA_CTRL  = 4'd0,
        RA_CFG   = 4'd1,
        RA_BUSY  = 4'd2,
        RA_LEVEL = 4'd3,
        RA_DATA  = 4'd4,
        RA_MASK  = 4'd5,
        RA_STAT  = 4'd6,
        RA_CLR   = 4'd7,
        RA_GO    = 4'd8
    } reg_addr_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_MARK,
        PH_SPACE
    } phase_e;

    // Width counters stop at all ones instead of wrapping.
    function automatic logic [WIDTH_W-1:0] sat_inc(input logic [WIDTH_W-1:0] v);
        return (v == {WIDTH_W{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/irrx_tick.sv
module irrx_tick #(
    parameter int UNIT_TICKS = 10,
    parameter int PW         = 7,
    localparam int UCW       = $clog2(UNIT_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] presc,
    input  logic          restart,
    output logic          unit
);

    typedef struct packed {
        logic [PW-1:0]  pcnt;
        logic [UCW-1:0] ucnt;
    } tick_t;

    tick_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart) begin
            // An edge on the line restarts the unit phase.
            s_d.pcnt = '0;
            s_d.ucnt = '0;
        end else if (s_q.pcnt == presc) begin
            s_d.pcnt = '0;
            if (s_q.ucnt == UCW'(UNIT_TICKS - 1)) begin
                s_d.ucnt = '0;
            end else begin
                s_d.ucnt = s_q.ucnt + 1'b1;
            end
        end else begin
            s_d.pcnt = s_q.pcnt + 1'b1;
        end
    end

    assign unit = !restart && (s_q.pcnt == presc) && (s_q.ucnt == UCW'(UNIT_TICKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/irrx_meter.sv
module irrx_meter
    import irrx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               invert,
    input  logic               unit,
    input  logic [WIDTH_W-1:0] max_w,
    input  logic               rx_in,
    output logic               restart,
    output logic               push,
    output logic [31:0]        push_word,
    output logic               tout
);

    typedef struct packed {
        logic               s1;
        logic               s2;
        logic               lvl;
        phase_e             phase;
        logic [WIDTH_W-1:0] mark;
        logic [WIDTH_W-1:0] space;
    } meter_t;

    meter_t m_d, m_q;
    logic cur, rise, fall;
    logic [WIDTH_W-1:0] sp_inc;
    logic [WIDTH_W:0] total;

    always_comb begin
        m_d       = m_q;
        m_d.s1    = rx_in;
        m_d.s2    = m_q.s1;
        cur       = m_q.s2 ^ invert;
        m_d.lvl   = cur;
        rise      = cur && !m_q.lvl;
        fall      = !cur && m_q.lvl;
        restart   = rise || fall;
        push      = 1'b0;
        tout      = 1'b0;
        push_word = '0;
        sp_inc    = sat_inc(m_q.space);
        total     = {1'b0, m_q.mark} + {1'b0, sp_inc};
        if (!run) begin
            m_d.phase = PH_IDLE;
            m_d.mark  = '0;
            m_d.space = '0;
        end else begin
            unique case (m_q.phase)
                PH_IDLE: begin
                    if (rise) begin
                        m_d.phase = PH_MARK;
                        m_d.mark  = '0;
                        m_d.space = '0;
                    end
                end
                PH_MARK: begin
                    if (fall)      m_d.phase = PH_SPACE;
                    else if (unit) m_d.mark  = sat_inc(m_q.mark);
                end
                PH_SPACE: begin
                    if (rise) begin
                        push      = 1'b1;
                        push_word = {m_q.space, m_q.mark};
                        m_d.phase = PH_MARK;
                        m_d.mark  = '0;
                        m_d.space = '0;
                    end else if (unit) begin
                        if (total >= {1'b0, max_w}) begin
                            push      = 1'b1;
                            tout      = 1'b1;
                            push_word = {sp_inc, m_q.mark};
                            m_d.phase = PH_IDLE;
                        end else begin
                            m_d.space = sp_inc;
                        end
                    end
                end
                default: m_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '{s1: 1'b0, s2: 1'b0, lvl: 1'b0, phase: PH_IDLE, mark: '0, space: '0};
        else        m_q <= m_d;
    end

endmodule

// File: rtl/irrx_fifo.sv
module irrx_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    localparam int PTRW = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          drop
);

    typedef struct packed {
        logic [PTRW-1:0] wp;
        logic [PTRW-1:0] rp;
        logic [CW-1:0]   cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic [DW-1:0] mem [DEPTH];
    logic do_pop, do_push;

    always_comb begin
        f_d     = f_q;
        do_pop  = pop && (f_q.cnt != '0);
        do_push = push && ((f_q.cnt != CW'(DEPTH)) || do_pop);
        drop    = push && !do_push;
        if (do_push) f_d.wp = (f_q.wp == PTRW'(DEPTH - 1)) ? '0 : f_q.wp + 1'b1;
        if (do_pop)  f_d.rp = (f_q.rp == PTRW'(DEPTH - 1)) ? '0 : f_q.rp + 1'b1;
        if (do_push && !do_pop)      f_d.cnt = f_q.cnt + 1'b1;
        else if (do_pop && !do_push) f_d.cnt = f_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[f_q.wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign head  = (f_q.cnt != '0) ? mem[f_q.rp] : '0;
    assign count = f_q.cnt;
    assign full  = (f_q.cnt == CW'(DEPTH));

endmodule

// File: rtl/irrx_capture.sv
module irrx_capture
    import irrx_pkg::*;
#(
    parameter int FIFO_DEPTH  = 64,
    parameter int UNIT_TICKS  = 10,
    parameter int BUSY_CYCLES = 4,
    localparam int CW         = $clog2(FIFO_DEPTH + 1),
    localparam int BCW        = $clog2(BUSY_CYCLES + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rx_in,
    output logic        irq
);

    typedef struct packed {
        logic           enable;
        logic [31:0]    cfg;
        logic [BCW-1:0] busy_cnt;
        logic           run;
        logic [2:0]     mask;
        logic [2:0]     stat;
    } regs_t;

    regs_t r_d, r_q;

    logic          busy, active, ctrl_on_wr;
    logic          restart, unit, mtr_push, mtr_tout;
    logic [31:0]   mtr_word, fifo_head;
    logic [CW-1:0] fifo_count;
    logic          fifo_full, fifo_drop, fifo_pop;
    logic [7:0]    rx_thr;
    logic          rx_hit;
    logic [2:0]    st_q, masked;
    logic [2:0]    clr_bits;

    assign busy       = (r_q.busy_cnt != '0);
    assign active     = r_q.run && r_q.cfg[7];
    assign ctrl_on_wr = bus_wr && (bus_addr == RA_CTRL) && bus_wdata[0];
    assign fifo_pop   = bus_rd && (bus_addr == RA_DATA);
    assign rx_thr     = {2'b00, r_q.cfg[13:8]} + 8'd1;
    assign rx_hit     = 32'(fifo_count) >= 32'(rx_thr);
    assign st_q       = r_q.stat;
    assign masked     = r_q.stat & ~r_q.mask;
    assign irq        = |masked;

    irrx_tick #(.UNIT_TICKS(UNIT_TICKS), .PW(7)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .presc   (r_q.cfg[6:0]),
        .restart (restart),
        .unit    (unit)
    );

    irrx_meter u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (active),
        .invert    (r_q.cfg[15:14] == 2'd1),
        .unit      (unit),
        .max_w     (r_q.cfg[31:16]),
        .rx_in     (rx_in),
        .restart   (restart),
        .push      (mtr_push),
        .push_word (mtr_word),
        .tout      (mtr_tout)
    );

    irrx_fifo #(.DEPTH(FIFO_DEPTH), .DW(32)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (mtr_push),
        .wdata (mtr_word),
        .pop   (fifo_pop),
        .head  (fifo_head),
        .count (fifo_count),
        .full  (fifo_full),
        .drop  (fifo_drop)
    );

    always_comb begin
        r_d      = r_q;
        clr_bits = '0;
        if (busy) r_d.busy_cnt = r_q.busy_cnt - 1'b1;
        if (bus_wr) begin
            unique case (bus_addr)
                RA_CTRL: begin
                    r_d.enable = bus_wdata[0];
                    if (bus_wdata[0]) r_d.busy_cnt = BCW'(BUSY_CYCLES);
                    else              r_d.run      = 1'b0;
                end
                RA_CFG:  r_d.cfg  = bus_wdata;
                RA_MASK: r_d.mask = bus_wdata[10:8];
                RA_CLR:  clr_bits = bus_wdata[18:16];
                RA_GO:   if (r_q.enable) r_d.run = 1'b1;
                default: ;
            endcase
        end
        r_d.stat = (r_q.stat & ~clr_bits) | {fifo_drop, mtr_tout, rx_hit};
    end

    always_comb begin
        unique case (bus_addr)
            RA_CTRL:  bus_rdata = {31'd0, r_q.enable};
            RA_CFG:   bus_rdata = r_q.cfg;
            RA_BUSY:  bus_rdata = {31'd0, busy};
            RA_LEVEL: bus_rdata = 32'(fifo_count);
            RA_DATA:  bus_rdata = fifo_head;
            RA_MASK:  bus_rdata = {21'd0, r_q.mask, 8'd0};
            RA_STAT:  bus_rdata = {5'd0, masked, 13'd0, r_q.stat, 8'd0};
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{enable: 1'b0, cfg: '0, busy_cnt: '0, run: 1'b0, mask: 3'b111, stat: 3'b000};
        else        r_q <= r_d;
    end

endmodule

// File: rtl/irrx_checker.sv
module irrx_checker #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_on_wr,
    input logic          busy,
    input logic          active,
    input logic          mtr_push,
    input logic          mtr_tout,
    input logic [CW-1:0] fifo_count,
    input logic          fifo_full,
    input logic          fifo_pop,
    input logic [7:0]    rx_thr,
    input logic [2:0]    st_q
);

    AST_BUSY_FROM_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctrl_on_wr)); // R1

    AST_NO_PUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mtr_push); // R2

    AST_TIMEOUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        mtr_tout |=> st_q[1]); // R6

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(fifo_count) <= DEPTH); // R7

    AST_RX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(fifo_count) >= 32'(rx_thr)) |=> st_q[0]); // R8

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mtr_push && fifo_full && !fifo_pop) |=> (st_q[2] && 32'(fifo_count) == DEPTH)); // R9

endmodule

bind irrx_capture irrx_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_on_wr (ctrl_on_wr),
    .busy       (busy),
    .active     (active),
    .mtr_push   (mtr_push),
    .mtr_tout   (mtr_tout),
    .fifo_count (fifo_count),
    .fifo_full  (fifo_full),
    .fifo_pop   (fifo_pop),
    .rx_thr     (rx_thr),
    .st_q       (st_q)
);

// File: tb/test_irrx_capture.sv
module test_irrx_capture;

    localparam int CLK_P = 10;
    localparam int DEPTH = 64;
    localparam int MAXW  = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_in = 1'b0;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    int unit_clk = 10;
    logic inv = 1'b0;
    bit finished = 0;
    logic [31:0] rv;
    logic [31:0] expq [$];

    always #(CLK_P/2) clk = ~clk;

    irrx_capture i_irrx_capture (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_in(rx_in), .irq(irq)
    );

    function automatic logic [31:0] pack_sym(int m, int s);
        return {16'(s), 16'(m)};
    endfunction

    function automatic logic [31:0] cfg_word(int maxw, int fmt, int lvl, int raw, int presc);
        return {16'(maxw), 2'(fmt), 6'(lvl), 1'(raw), 7'(presc)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic line(logic lv, int cycles);
        rx_in = lv ^ inv;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic sym(int m, int s);
        line(1'b1, m * unit_clk + unit_clk / 2);
        line(1'b0, s * unit_clk + unit_clk / 2);
    endtask

    task automatic tail(int m);
        line(1'b1, m * unit_clk + unit_clk / 2);
        line(1'b0, MAXW * unit_clk + 50);
    endtask

    task automatic restart_cap(logic [31:0] cfg);
        wr(4'd0, 32'd0);
        line(1'b0, 4);
        wr(4'd1, cfg);
        wr(4'd0, 32'd1);
        repeat (6) @(negedge clk);
        wr(4'd8, 32'h5A);
        wr(4'd7, 32'h0007_0000);
    endtask

    task automatic drain_check(string req);
        while (expq.size() > 0) begin
            rd(4'd4, rv);
            check(req, rv, expq.pop_front());
        end
        rd(4'd3, rv);
        check("R7 level after drain", rv, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq at reset", {31'd0, irq}, 32'd0);
        rd(4'd2, rv); check("R1 busy at reset", rv, 32'd0);
        rd(4'd3, rv); check("R1 level at reset", rv, 32'd0);

        // R2 nothing captured before enable/start
        sym(2, 2); line(1'b1, 20); line(1'b0, 20);
        rd(4'd3, rv); check("R2 no capture before start", rv, 32'd0);

        // R1 busy window
        wr(4'd0, 32'd1);
        rd(4'd2, rv); check("R1 busy after enable", rv, 32'd1);
        repeat (6) @(negedge clk);
        rd(4'd2, rv); check("R1 busy released", rv, 32'd0);

        // R2 raw bit off: no capture even after start
        wr(4'd1, cfg_word(MAXW, 0, 3, 0, 0));
        wr(4'd8, 32'd0);
        sym(2, 3); tail(2);
        rd(4'd3, rv); check("R2 raw bit off", rv, 32'd0);

        // R3 R4 R6 R7 R8 random symbols, format 0
        restart_cap(cfg_word(MAXW, 0, 3, 1, 0));
        wr(4'd5, 32'd0);
        for (int i = 0; i < 6; i++) begin
            int m = 1 + int'($urandom_range(5));
            int s = 1 + int'($urandom_range(5));
            if (i < 5) begin
                sym(m, s); expq.push_back(pack_sym(m, s));
            end else begin
                tail(m); expq.push_back(pack_sym(m, MAXW - m));
            end
        end
        rd(4'd3, rv); check("R7 level after burst", rv, 32'd6);
        rd(4'd6, rv); check("R6 timeout status", {31'd0, rv[9]}, 32'd1);
        check("R8 receive status above level", {31'd0, rv[8]}, 32'd1);
        check("R11 irq with mask open", {31'd0, irq}, 32'd1);
        drain_check("R3 R4 entry order");
        rd(4'd4, rv); check("R7 empty read", rv, 32'd0);

        // R10 selective clear
        wr(4'd7, 32'h0002_0000);
        rd(4'd6, rv); check("R10 timeout cleared", {29'd0, rv[10:8]}, 32'd1);
        wr(4'd7, 32'h0001_0000);
        rd(4'd6, rv); check("R10 receive cleared", {29'd0, rv[10:8]}, 32'd0);

        // R8 below threshold then reaching it
        sym(3, 1); sym(1, 4); tail(2);
        expq.push_back(pack_sym(3, 1)); expq.push_back(pack_sym(1, 4)); expq.push_back(pack_sym(2, MAXW - 2));
        rd(4'd6, rv); check("R8 receive clear below level", {31'd0, rv[8]}, 32'd0);
        tail(5); expq.push_back(pack_sym(5, MAXW - 5));
        rd(4'd6, rv); check("R8 receive at level", {31'd0, rv[8]}, 32'd1);
        drain_check("R6 timeout entries");

        // R11 mask
        wr(4'd7, 32'h0007_0000);
        wr(4'd5, 32'h0000_0200);
        tail(1); expq.push_back(pack_sym(1, MAXW - 1));
        rd(4'd6, rv);
        check("R11 raw timeout", {31'd0, rv[9]}, 32'd1);
        check("R11 masked copy hidden", {29'd0, rv[26:24]}, 32'd0);
        check("R11 irq masked", {31'd0, irq}, 32'd0);
        wr(4'd5, 32'd0);
        rd(4'd6, rv); check("R11 masked copy shown", {29'd0, rv[26:24]}, 32'd2);
        check("R11 irq unmasked", {31'd0, irq}, 32'd1);
        drain_check("R6 single timeout");

        // R5 inverted polarity
        inv = 1'b1;
        restart_cap(cfg_word(MAXW, 1, 3, 1, 0));
        sym(2, 3); tail(4);
        expq.push_back(pack_sym(2, 3)); expq.push_back(pack_sym(4, MAXW - 4));
        drain_check("R5 format 1 entries");
        inv = 1'b0;

        // R3 prescaler 1: unit = 20 cycles
        unit_clk = 20;
        restart_cap(cfg_word(MAXW, 0, 3, 1, 1));
        sym(4, 2); tail(3);
        expq.push_back(pack_sym(4, 2)); expq.push_back(pack_sym(3, MAXW - 3));
        drain_check("R3 prescaler entries");
        unit_clk = 10;

        // R9 overflow: 66 closes into a 64-deep FIFO
        restart_cap(cfg_word(MAXW, 0, 63, 1, 0));
        for (int i = 0; i < 65; i++) sym(1, 1);
        tail(1);
        rd(4'd3, rv); check("R9 level held at depth", rv, DEPTH);
        rd(4'd6, rv); check("R9 overflow status", {31'd0, rv[10]}, 32'd1);
        for (int i = 0; i < DEPTH; i++) expq.push_back(pack_sym(1, 1));
        drain_check("R9 kept entries");
        wr(4'd7, 32'h0004_0000);
        rd(4'd6, rv); check("R10 overflow cleared", {31'd0, rv[10]}, 32'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule